// File: doc/BRIEF.md
# Paravirtual Device Control Register Block

This block is the register file a legacy-style paravirtual device exposes through an I/O region. A host bridge sends byte, halfword and word accesses over a single-beat request bus. Every request is answered one cycle later. The block decodes a common header at the start of the region. The header holds feature words, per-queue page-frame and vector registers, queue select and size, a notify doorbell, the device status byte and a read-to-clear interrupt status byte. The block also drives a legacy level interrupt.

The header is 20 bytes long while message-signalled interrupts are off. It grows to 24 bytes when they are on, because two vector registers are added at its end. Any access at or beyond the current header length is passed to a device-specific configuration window, rebased to offset zero. A doorbell write is reported as a one-cycle pulse that carries the written value. Writing zero to the status byte, or to the page-frame register, resets the device state.

Top module: `pvdev_regs`

## Requirements
- R1: After reset these read as zero: guest features, status, queue select, interrupt status, and every queue's page frame. Both vector registers read 0xFFFF. The irq, resp_valid, cfg_valid and notify_valid outputs are low.
- R2: A read at offset 0 returns the HOST_FEAT parameter ORed with bits 24, 28 and 30.
- R3: A write at offset 4 stores the written value as the guest features, readable at offset 4. If bit 30 of the written value is set, FALLBACK_FEAT is stored instead.
- R4: A non-zero write at offset 8 stores a page frame for the currently selected queue, and a read at offset 8 returns that queue's frame. A write of zero stores nothing and performs the R6 device reset.
- R5: A write at offset 14 changes the queue selection only when the value is below NQ; otherwise the previous selection is kept. A read at offset 14 returns the selection. A read at offset 12 returns QLEN.
- R6: A write at offset 18 keeps the low 8 bits of the value as the status byte. If those 8 bits are zero, the device resets: guest features, status, selection, interrupt status, all page frames and all vectors return to their R1 values.
- R7: Bits on isr_raise are ORed into the interrupt status byte at offset 19. A read at offset 19 returns the current byte and clears it, and bits raised in the same cycle are kept. In the cycle after any change, irq equals bit 0 of the byte while msi_en is low; irq is low while msi_en is high.
- R8: While msi_en is high, offset 20 is the config-change vector and offset 22 is the vector of the selected queue. A written value below NUM_VEC is stored; any other value stores 0xFFFF.
- R9: An access at an offset at or above the header length (20, or 24 with msi_en high) raises cfg_valid in the next cycle. cfg_off is the offset minus the header length, and cfg_write and the size-masked cfg_wdata are carried with it. A read returns cfg_rdata masked to the access size.
- R10: Inside the header, reads at unassigned offsets and at the doorbell offset 16 return all ones masked to the access size. Writes to unassigned offsets and to the read-only offsets 0, 12 and 19 change nothing.
- R11: A write at offset 16 raises notify_valid for one cycle, in the next cycle, with notify_idx equal to the low 16 bits of the size-masked value.
- R12: Each request receives resp_valid exactly one cycle later. req_size is 0 for a byte, 1 for a halfword and 2 or 3 for a word. Write data is masked to the size before use, read data is masked to the size, and writes return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msi_en | input | 1 | Message-signalled interrupts enabled |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_addr | input | AW | Offset within the I/O region |
| req_wdata | input | 32 | Write data, right-aligned |
| resp_valid | output | 1 | Response strobe, one cycle after request |
| resp_rdata | output | 32 | Read data, masked to access size |
| cfg_valid | output | 1 | Device-config window access strobe |
| cfg_write | output | 1 | Window access is a write |
| cfg_size | output | 2 | Window access size |
| cfg_off | output | AW | Offset inside the window |
| cfg_wdata | output | 32 | Window write data |
| cfg_rdata | input | 32 | Window read data for cfg_off, same cycle |
| isr_raise | input | 8 | Interrupt status bits to set |
| irq | output | 1 | Legacy level interrupt |
| notify_valid | output | 1 | Doorbell pulse |
| notify_idx | output | 16 | Value written to the doorbell |

## Verification
The bench builds the block with NQ=4, NUM_VEC=3, QLEN=64 and a non-zero FALLBACK_FEAT. With these values the selection boundary (3 accepted, 4 rejected) and the vector boundary (2 accepted, 3 rejected) each take only a few accesses. A fallback mask that differs from zero shows that the replacement path was taken rather than a plain store. Toggling msi_en between accesses exercises both header lengths, so the window rebasing is tested at 20 and at 24.

// File: rtl/pvdev_pkg.sv
package pvdev_pkg;

  // header offsets; a driver decodes these positions, so they are fixed
  localparam int OFS_HOST_FEAT  = 0;
  localparam int OFS_GUEST_FEAT = 4;
  localparam int OFS_QPFN       = 8;
  localparam int OFS_QLEN       = 12;
  localparam int OFS_QSEL       = 14;
  localparam int OFS_NOTIFY     = 16;
  localparam int OFS_STATUS     = 18;
  localparam int OFS_ISR        = 19;
  localparam int OFS_CFG_VEC    = 20;
  localparam int OFS_Q_VEC      = 22;

  localparam int HDR_LEN_LEGACY = 20;
  localparam int HDR_LEN_MSG    = 24;

  localparam int FEAT_NOTIFY_EMPTY = 24;
  localparam int FEAT_INDIRECT     = 28;
  localparam int FEAT_BAD          = 30;
  localparam logic [31:0] FIXED_FEATS = (32'h1 << FEAT_NOTIFY_EMPTY)
                                      | (32'h1 << FEAT_INDIRECT)
                                      | (32'h1 << FEAT_BAD);

  localparam logic [15:0] NO_VECTOR = 16'hFFFF;

  typedef enum logic [3:0] {
    RG_NONE, RG_HOST_FEAT, RG_GUEST_FEAT, RG_QPFN, RG_QLEN, RG_QSEL,
    RG_NOTIFY, RG_STATUS, RG_ISR, RG_CFG_VEC, RG_Q_VEC
  } reg_id_e;

  function automatic logic [31:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    size_mask = 32'h0000_00FF;
      2'd1:    size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/pvdev_decode.sv
module pvdev_decode
  import pvdev_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW-1:0] addr,
  input  logic          msg_en,
  output reg_id_e       rid,
  output logic          in_win,
  output logic [AW-1:0] win_off
);
  localparam logic [AW-1:0] LEN_LEGACY = AW'(HDR_LEN_LEGACY);
  localparam logic [AW-1:0] LEN_MSG    = AW'(HDR_LEN_MSG);

  logic [AW-1:0] hdr_len;

  always_comb begin
    hdr_len = msg_en ? LEN_MSG : LEN_LEGACY;
    in_win  = (addr >= hdr_len);
    win_off = addr - hdr_len;
    rid     = RG_NONE;
    if (!in_win) begin
      case (int'(addr))
        OFS_HOST_FEAT:  rid = RG_HOST_FEAT;
        OFS_GUEST_FEAT: rid = RG_GUEST_FEAT;
        OFS_QPFN:       rid = RG_QPFN;
        OFS_QLEN:       rid = RG_QLEN;
        OFS_QSEL:       rid = RG_QSEL;
        OFS_NOTIFY:     rid = RG_NOTIFY;
        OFS_STATUS:     rid = RG_STATUS;
        OFS_ISR:        rid = RG_ISR;
        OFS_CFG_VEC:    rid = RG_CFG_VEC;
        OFS_Q_VEC:      rid = RG_Q_VEC;
        default:        rid = RG_NONE;
      endcase
    end
  end
endmodule

// File: rtl/pvdev_queue_table.sv
module pvdev_queue_table
  import pvdev_pkg::*;
#(
  parameter int NQ  = 8,
  parameter int QSW = 3
) (
  input  logic           clk,
  input  logic           clr,
  input  logic [QSW-1:0] sel,
  input  logic           pfn_we,
  input  logic [31:0]    pfn_wd,
  input  logic           vec_we,
  input  logic [15:0]    vec_wd,
  output logic [31:0]    pfn_rd,
  output logic [15:0]    vec_rd
);
  logic [31:0] pfn_mem [NQ];
  logic [15:0] vec_mem [NQ];

  always_ff @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < NQ; i++) begin
        pfn_mem[i] <= '0;
        vec_mem[i] <= NO_VECTOR;
      end
    end else begin
      if (pfn_we) pfn_mem[sel] <= pfn_wd;
      if (vec_we) vec_mem[sel] <= vec_wd;
    end
  end

  assign pfn_rd = pfn_mem[sel];
  assign vec_rd = vec_mem[sel];
endmodule

// File: rtl/pvdev_isr.sv
module pvdev_isr (
  input  logic       clk,
  input  logic       clr,
  input  logic       rd_ack,
  input  logic [7:0] raise,
  input  logic       legacy_en,
  output logic [7:0] isr_q,
  output logic       irq_q
);
  logic [7:0] isr_next;

  always_comb begin
    isr_next = (rd_ack ? 8'h00 : isr_q) | raise;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      isr_q <= 8'h00;
      irq_q <= 1'b0;
    end else begin
      isr_q <= isr_next;
      irq_q <= isr_next[0] & legacy_en;
    end
  end
endmodule

// File: rtl/pvdev_regs.sv
module pvdev_regs
  import pvdev_pkg::*;
#(
  parameter int          AW            = 8,
  parameter int          NQ            = 8,
  parameter int          NUM_VEC       = 4,
  parameter int          QLEN          = 256,
  parameter logic [31:0] HOST_FEAT     = 32'h0000_0021,
  parameter logic [31:0] FALLBACK_FEAT = 32'h0000_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          msi_en,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          resp_valid,
  output logic [31:0]   resp_rdata,
  output logic          cfg_valid,
  output logic          cfg_write,
  output logic [1:0]    cfg_size,
  output logic [AW-1:0] cfg_off,
  output logic [31:0]   cfg_wdata,
  input  logic [31:0]   cfg_rdata,
  input  logic [7:0]    isr_raise,
  output logic          irq,
  output logic          notify_valid,
  output logic [15:0]   notify_idx
);
  localparam int QSW = (NQ > 1) ? $clog2(NQ) : 1;
  localparam logic [31:0] QLEN_WORD = 32'(QLEN) & 32'h0000_FFFF;

  reg_id_e       rid;
  logic          in_win;
  logic [AW-1:0] win_off;

  pvdev_decode #(.AW(AW)) u_dec (
    .addr    (req_addr),
    .msg_en  (msi_en),
    .rid     (rid),
    .in_win  (in_win),
    .win_off (win_off)
  );

  logic [31:0] wmask, wd;
  logic        hdr_wr, hdr_rd, soft_rst, clr;
  logic [15:0] vec_val;

  always_comb begin
    wmask    = size_mask(req_size);
    wd       = req_wdata & wmask;
    hdr_wr   = req_valid & req_write & ~in_win;
    hdr_rd   = req_valid & ~req_write & ~in_win;
    soft_rst = hdr_wr & (((rid == RG_STATUS) && (wd[7:0] == 8'h00)) ||
                         ((rid == RG_QPFN) && (wd == 32'h0)));
    clr      = rst | soft_rst;
    vec_val  = (wd < 32'(NUM_VEC)) ? wd[15:0] : NO_VECTOR;
  end

  // device control state
  logic [31:0]    guest_feat_q;
  logic [7:0]     status_q;
  logic [QSW-1:0] qsel_q;
  logic [15:0]    cfg_vec_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      guest_feat_q <= '0;
      status_q     <= '0;
      qsel_q       <= '0;
      cfg_vec_q    <= NO_VECTOR;
    end else if (hdr_wr) begin
      case (rid)
        RG_GUEST_FEAT: guest_feat_q <= wd[FEAT_BAD] ? FALLBACK_FEAT : wd;
        RG_STATUS:     status_q     <= wd[7:0];
        RG_QSEL:       if (wd < 32'(NQ)) qsel_q <= wd[QSW-1:0];
        RG_CFG_VEC:    cfg_vec_q    <= vec_val;
        default:       ;
      endcase
    end
  end

  logic [31:0] pfn_rd;
  logic [15:0] qvec_rd;

  pvdev_queue_table #(.NQ(NQ), .QSW(QSW)) u_qtab (
    .clk    (clk),
    .clr    (clr),
    .sel    (qsel_q),
    .pfn_we (hdr_wr && (rid == RG_QPFN) && (wd != 32'h0)),
    .pfn_wd (wd),
    .vec_we (hdr_wr && (rid == RG_Q_VEC)),
    .vec_wd (vec_val),
    .pfn_rd (pfn_rd),
    .vec_rd (qvec_rd)
  );

  logic [7:0] isr_q;
  logic       irq_q;

  pvdev_isr u_isr (
    .clk       (clk),
    .clr       (clr),
    .rd_ack    (hdr_rd && (rid == RG_ISR)),
    .raise     (isr_raise),
    .legacy_en (~msi_en),
    .isr_q     (isr_q),
    .irq_q     (irq_q)
  );
  assign irq = irq_q;

  // header read mux
  logic [31:0] hdr_val;
  always_comb begin
    case (rid)
      RG_HOST_FEAT:  hdr_val = HOST_FEAT | FIXED_FEATS;
      RG_GUEST_FEAT: hdr_val = guest_feat_q;
      RG_QPFN:       hdr_val = pfn_rd;
      RG_QLEN:       hdr_val = QLEN_WORD;
      RG_QSEL:       hdr_val = 32'(qsel_q);
      RG_STATUS:     hdr_val = {24'h0, status_q};
      RG_ISR:        hdr_val = {24'h0, isr_q};
      RG_CFG_VEC:    hdr_val = {16'h0, cfg_vec_q};
      RG_Q_VEC:      hdr_val = {16'h0, qvec_rd};
      default:       hdr_val = 32'hFFFF_FFFF;
    endcase
  end

  // response and forwarding registers
  logic        resp_valid_q, resp_win_q;
  logic [1:0]  resp_size_q;
  logic [31:0] resp_data_q;
  logic        cfg_valid_q, cfg_write_q;
  logic [1:0]  cfg_size_q;
  logic [AW-1:0] cfg_off_q;
  logic [31:0] cfg_wdata_q;
  logic        notify_valid_q;
  logic [15:0] notify_idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid_q   <= 1'b0;
      resp_win_q     <= 1'b0;
      resp_size_q    <= 2'd0;
      resp_data_q    <= '0;
      cfg_valid_q    <= 1'b0;
      cfg_write_q    <= 1'b0;
      cfg_size_q     <= 2'd0;
      cfg_off_q      <= '0;
      cfg_wdata_q    <= '0;
      notify_valid_q <= 1'b0;
      notify_idx_q   <= '0;
    end else begin
      resp_valid_q   <= req_valid;
      resp_win_q     <= req_valid & in_win & ~req_write;
      resp_size_q    <= req_size;
      resp_data_q    <= (req_valid && !req_write) ? (hdr_val & wmask) : 32'h0;
      cfg_valid_q    <= req_valid & in_win;
      notify_valid_q <= hdr_wr && (rid == RG_NOTIFY);
      if (req_valid && in_win) begin
        cfg_write_q <= req_write;
        cfg_size_q  <= req_size;
        cfg_off_q   <= win_off;
        cfg_wdata_q <= wd;
      end
      if (hdr_wr && (rid == RG_NOTIFY)) notify_idx_q <= wd[15:0];
    end
  end

  assign resp_valid   = resp_valid_q;
  assign resp_rdata   = resp_win_q ? (cfg_rdata & size_mask(resp_size_q)) : resp_data_q;
  assign cfg_valid    = cfg_valid_q;
  assign cfg_write    = cfg_write_q;
  assign cfg_size     = cfg_size_q;
  assign cfg_off      = cfg_off_q;
  assign cfg_wdata    = cfg_wdata_q;
  assign notify_valid = notify_valid_q;
  assign notify_idx   = notify_idx_q;
endmodule

// File: rtl/pvdev_regs_chk.sv
module pvdev_regs_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          msi_en,
  input logic          req_valid,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [7:0]    isr_raise,
  input logic          resp_valid,
  input logic          cfg_valid,
  input logic          irq,
  input logic          notify_valid
);
  p_resp_next_r12: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_valid);

  p_resp_has_req_r12: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> $past(req_valid));

  p_win_fwd_r9: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |-> (resp_valid && $past(req_valid)));

  p_notify_from_write_r11: assert property (@(posedge clk) disable iff (rst)
    notify_valid |-> $past(req_valid && req_write));

  p_irq_legacy_only_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> !$past(msi_en));

  p_isr_read_drops_irq_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && (req_addr == AW'(19)) && (isr_raise == 8'h00))
      |=> !irq);
endmodule

bind pvdev_regs pvdev_regs_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .msi_en       (msi_en),
  .req_valid    (req_valid),
  .req_write    (req_write),
  .req_addr     (req_addr),
  .isr_raise    (isr_raise),
  .resp_valid   (resp_valid),
  .cfg_valid    (cfg_valid),
  .irq          (irq),
  .notify_valid (notify_valid)
);

// File: tb/pvdev_regs_test.sv
module pvdev_regs_test;
  localparam int          AW   = 8;
  localparam int          NQ   = 4;
  localparam int          NV   = 3;
  localparam int          QL   = 64;
  localparam logic [31:0] HF   = 32'h0000_0021;
  localparam logic [31:0] FALL = 32'h0000_0003;

  logic clk = 1'b0, rst = 1'b1, msi_en = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_size = 2'd2;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [7:0] isr_raise = '0;
  logic resp_valid, cfg_valid, cfg_write, irq, notify_valid;
  logic [31:0] resp_rdata, cfg_wdata, cfg_rdata;
  logic [1:0] cfg_size;
  logic [AW-1:0] cfg_off;
  logic [15:0] notify_idx;

  always #4 clk = ~clk;

  assign cfg_rdata = {16'hC0DE, 8'h00, cfg_off};

  pvdev_regs #(.AW(AW), .NQ(NQ), .NUM_VEC(NV), .QLEN(QL),
               .HOST_FEAT(HF), .FALLBACK_FEAT(FALL)) uut (
    .clk(clk), .rst(rst), .msi_en(msi_en),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_size(cfg_size),
    .cfg_off(cfg_off), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .isr_raise(isr_raise), .irq(irq),
    .notify_valid(notify_valid), .notify_idx(notify_idx)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  string cur_tag = "R1";

  // behavioural reference state
  logic [31:0] m_guest, m_pfn [NQ];
  logic [15:0] m_vec [NQ];
  logic [15:0] m_cvec;
  logic [7:0]  m_status, m_isr;
  int          m_sel;
  // expected outputs
  logic        e_resp_valid, e_cfg_valid, e_cfg_write, e_notify, e_irq;
  logic [31:0] e_resp, e_cfg_wdata;
  logic [AW-1:0] e_cfg_off;
  logic [15:0] e_nidx;
  string       e_tag = "R1";

  task automatic model_reset();
    m_guest = 0; m_status = 0; m_isr = 0; m_sel = 0; m_cvec = 16'hFFFF;
    for (int i = 0; i < NQ; i++) begin m_pfn[i] = 0; m_vec[i] = 16'hFFFF; end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      model_reset();
      e_resp_valid = 0; e_cfg_valid = 0; e_notify = 0; e_irq = 0; e_resp = 0;
    end else begin
      int hdr, a;
      logic [31:0] mask, wd, v;
      bit rd_isr, do_rst;
      hdr = msi_en ? 24 : 20;
      a = int'(req_addr);
      mask = (req_size == 0) ? 32'hFF : (req_size == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
      wd = req_wdata & mask;
      rd_isr = 0; do_rst = 0;
      e_resp_valid = req_valid; e_cfg_valid = 0; e_notify = 0;
      if (req_valid) begin
        e_tag = cur_tag;
        e_resp = 0;
        if (a >= hdr) begin
          e_cfg_valid = 1; e_cfg_off = AW'(a - hdr);
          e_cfg_write = req_write; e_cfg_wdata = wd;
          if (!req_write) e_resp = {16'hC0DE, 8'h00, 8'(a - hdr)} & mask;
        end else if (!req_write) begin
          v = 32'hFFFF_FFFF;
          case (a)
            0:  v = HF | 32'h5100_0000;
            4:  v = m_guest;
            8:  v = m_pfn[m_sel];
            12: v = QL;
            14: v = m_sel;
            18: v = {24'h0, m_status};
            19: begin v = {24'h0, m_isr}; rd_isr = 1; end
            20: v = {16'h0, m_cvec};
            22: v = {16'h0, m_vec[m_sel]};
            default: v = 32'hFFFF_FFFF;
          endcase
          e_resp = v & mask;
        end else begin
          case (a)
            4:  m_guest = wd[30] ? FALL : wd;
            8:  if (wd == 0) do_rst = 1; else m_pfn[m_sel] = wd;
            14: if (wd < NQ) m_sel = int'(wd);
            16: begin e_notify = 1; e_nidx = wd[15:0]; end
            18: begin m_status = wd[7:0]; if (wd[7:0] == 0) do_rst = 1; end
            20: m_cvec = (wd < NV) ? wd[15:0] : 16'hFFFF;
            22: m_vec[m_sel] = (wd < NV) ? wd[15:0] : 16'hFFFF;
            default: ;
          endcase
        end
      end
      m_isr = (rd_isr ? 8'h00 : m_isr) | isr_raise;
      if (do_rst) model_reset();
      e_irq = m_isr[0] && !msi_en;
    end
  end

  task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string tag, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (rst) begin
        cmp(32'(resp_valid), 0, "R1", "resp_valid in reset");
        cmp(32'(irq), 0, "R1", "irq in reset");
        cmp(32'(cfg_valid), 0, "R1", "cfg_valid in reset");
        cmp(32'(notify_valid), 0, "R1", "notify_valid in reset");
      end else begin
        cmp(32'(resp_valid), 32'(e_resp_valid), "R12", "resp_valid");
        if (e_resp_valid) cmp(resp_rdata, e_resp, e_tag, "resp_rdata");
        cmp(32'(irq), 32'(e_irq), "R7", "irq");
        cmp(32'(notify_valid), 32'(e_notify), "R11", "notify_valid");
        if (e_notify) cmp(32'(notify_idx), 32'(e_nidx), "R11", "notify_idx");
        cmp(32'(cfg_valid), 32'(e_cfg_valid), "R9", "cfg_valid");
        if (e_cfg_valid) begin
          cmp(32'(cfg_off), 32'(e_cfg_off), "R9", "cfg_off");
          cmp(32'(cfg_write), 32'(e_cfg_write), "R9", "cfg_write");
          if (e_cfg_write) cmp(cfg_wdata, e_cfg_wdata, "R9", "cfg_wdata");
        end
      end
    end
  end

  task automatic acc(input bit w, input logic [1:0] sz, input int a, input logic [31:0] d, input string tag);
    @(negedge clk);
    cur_tag = tag;
    req_valid = 1'b1; req_write = w; req_size = sz;
    req_addr = AW'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic raise(input logic [7:0] b);
    @(negedge clk); isr_raise = b;
    @(negedge clk); isr_raise = 8'h00;
  endtask

  task automatic set_msi(input bit m);
    @(negedge clk); msi_en = m;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset values
    acc(0, 2, 4, 0, "R1"); acc(0, 2, 8, 0, "R1"); acc(0, 1, 14, 0, "R1");
    acc(0, 0, 18, 0, "R1"); acc(0, 0, 19, 0, "R1");
    set_msi(1); acc(0, 1, 20, 0, "R1"); acc(0, 1, 22, 0, "R1"); set_msi(0);
    // R2 host features
    acc(0, 2, 0, 0, "R2"); acc(0, 1, 0, 0, "R2"); acc(0, 0, 0, 0, "R2");
    // R3 guest features and fallback
    acc(1, 2, 4, 32'h1234_5678, "R3"); acc(0, 2, 4, 0, "R3");
    acc(1, 2, 4, 32'h4000_0001, "R3"); acc(0, 2, 4, 0, "R3");
    // R5 queue select bounds and size
    acc(1, 1, 14, 2, "R5"); acc(0, 1, 14, 0, "R5");
    acc(1, 1, 14, 4, "R5"); acc(0, 1, 14, 0, "R5");
    acc(1, 1, 14, 3, "R5"); acc(0, 1, 14, 0, "R5"); acc(0, 1, 12, 0, "R5");
    // R4 page frames per queue and zero-write reset
    acc(1, 2, 8, 32'h000A_BCDE, "R4");
    acc(1, 1, 14, 1, "R4"); acc(1, 2, 8, 32'h77, "R4");
    acc(0, 2, 8, 0, "R4");
    acc(1, 1, 14, 3, "R4"); acc(0, 2, 8, 0, "R4");
    acc(1, 0, 8, 32'h0000_0100, "R4");
    acc(0, 1, 14, 0, "R4"); acc(0, 2, 8, 0, "R4"); acc(0, 2, 4, 0, "R4");
    acc(1, 1, 14, 3, "R4"); acc(0, 2, 8, 0, "R4");
    // R6 status byte and reset on zero
    acc(1, 2, 4, 32'h55, "R6");
    acc(1, 0, 18, 32'h0F, "R6"); acc(0, 0, 18, 0, "R6");
    acc(1, 2, 18, 32'h1234_5607, "R6"); acc(0, 0, 18, 0, "R6");
    acc(1, 1, 18, 32'h0100, "R6"); acc(0, 0, 18, 0, "R6"); acc(0, 2, 4, 0, "R6");
    acc(0, 1, 14, 0, "R6");
    // R7 interrupt status and legacy line
    raise(8'h01); acc(0, 0, 19, 0, "R7"); acc(0, 0, 19, 0, "R7");
    raise(8'h02); acc(0, 2, 19, 0, "R7");
    set_msi(1); raise(8'h01); acc(0, 0, 19, 32'h0, "R7"); set_msi(0);
    raise(8'h05); set_msi(1); set_msi(0); acc(0, 0, 19, 0, "R7");
    // R8 vectors
    set_msi(1);
    acc(1, 1, 20, 2, "R8"); acc(0, 1, 20, 0, "R8");
    acc(1, 1, 20, 3, "R8"); acc(0, 1, 20, 0, "R8");
    acc(1, 1, 14, 1, "R8"); acc(1, 1, 22, 0, "R8"); acc(0, 1, 22, 0, "R8");
    acc(1, 1, 14, 2, "R8"); acc(0, 1, 22, 0, "R8");
    acc(1, 1, 22, 16'hFFFF, "R8"); acc(0, 1, 22, 0, "R8");
    // R9 device-config window at both header lengths
    acc(0, 2, 24, 0, "R9"); acc(1, 1, 30, 32'hBEEF_1234, "R9");
    set_msi(0);
    acc(0, 2, 20, 0, "R9"); acc(0, 0, 21, 0, "R9"); acc(0, 1, 23, 0, "R9");
    acc(1, 2, 22, 32'h0000_0001, "R9");
    // R10 unmapped and read-only offsets
    acc(0, 2, 1, 0, "R10"); acc(0, 1, 13, 0, "R10"); acc(0, 2, 16, 0, "R10");
    acc(1, 2, 0, 32'hFFFF_FFFF, "R10"); acc(0, 2, 0, 0, "R10");
    acc(1, 1, 12, 32'h0005, "R10"); acc(0, 1, 12, 0, "R10");
    acc(1, 0, 19, 32'h01, "R10"); acc(0, 0, 19, 0, "R10");
    acc(1, 2, 2, 32'h9999, "R10"); acc(0, 2, 4, 0, "R10");
    // R11 doorbell
    acc(1, 1, 16, 3, "R11"); acc(1, 0, 16, 32'h1FF, "R11");
    // R12 size masking on reads
    acc(1, 2, 4, 32'hA1B2_C3D4, "R12"); acc(0, 0, 4, 0, "R12"); acc(0, 1, 4, 0, "R12");
    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL R12 watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end
endmodule